// File: doc/BRIEF.md
# Windowed Device-Chain Start Controller

This controller drives a chain of `NDEV` time-addressed memory devices. Each device sweeps its locations by itself once it gets a start pulse. The device raises a last-row flag when its sweep ends. Software loads a window of device indices, a first index and a final index. The controller then enables only the devices inside that window and starts the first of them. It forwards each in-window last-row flag as a start pulse to the next device in the chain. When the final device of the window finishes, it restarts the first device, so the window is swept over and over.

A device index is a location divided by the per-device capacity. For example, with 64M locations per device, locations 193M to 520M map to zero-based indices 3 through 8. A window loaded while a sweep is running is held as pending and takes effect only at the next wrap point. A load whose final index is below its first index is refused and raises an error flag. `NDEV` is a power of two of at least 2.

The controller is a three-state machine:
- `ST_IDLE` means no window is active.
- `ST_RUN` means a window is active and nothing is queued.
- `ST_RUN_PEND` means a window is active and a replacement is queued.

The transitions are as follows:
- An accepted load takes `ST_IDLE` to `ST_RUN` and issues the first start pulse.
- An accepted load takes `ST_RUN` to `ST_RUN_PEND`.
- A wrap in `ST_RUN` stays in `ST_RUN` and restarts the same first device.
- A wrap in `ST_RUN_PEND` adopts the queued window and goes to `ST_RUN`. If an accepted load arrives in the same cycle, the state stays `ST_RUN_PEND` with that load queued.
- An accepted load in `ST_RUN_PEND` replaces the queued window.
- A refused load never changes the state.

Top module: `devwin_ctrl`

## Requirements
- R1: After reset every start pulse, every enable and the error flag are 0, and no window is active.
- R2: While a window is active, enable `i` is 1 exactly when first ≤ i ≤ final. With no window active, all enables are 0. Enables follow the active window in the cycle after it is adopted.
- R3: An accepted load with no active window gives a start pulse on the first device only. The pulse appears in the cycle after the load and lasts one cycle.
- R4: A last-row flag on an in-window device `i` other than the final one gives a one-cycle start pulse on device `i+1` in the next cycle.
- R5: A last-row flag on the final device of the window gives a one-cycle start pulse on the first device in the next cycle.
- R6: Last-row flags from devices outside the window cause no start pulse. A start pulse never goes to a device whose enable is 0.
- R7: A load with final < first is refused, and the error flag is 1 from the next cycle. The window, the enables and any pending window stay unchanged. The next accepted load clears the flag.
- R8: An accepted load while a window is active changes nothing until the final device's last-row flag. In the cycle after that flag, the new window's enables apply and the start pulse goes to the new first device.
- R9: With 16 devices of 64M locations, the window for locations 193M to 520M uses indices 3 and 8, and enables 0x01F8.
- R10: A second accepted load before the wrap replaces the pending window. Only the latest one is adopted at the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | One-cycle request to load a new window |
| load_first | input | IDX_W | First device index of the requested window |
| load_final | input | IDX_W | Final device index of the requested window |
| last_row | input | NDEV | Per-device end-of-sweep flag |
| dev_start | output | NDEV | Per-device one-cycle start pulse |
| dev_en | output | NDEV | Per-device enable for the active window |
| cfg_err | output | 1 | Set by a refused load, cleared by an accepted one |

## Verification
The single-pulse assertion relies on at most one in-window device raising its last-row flag in any cycle, as real chained devices do. The random stimulus therefore never drives more than one last-row bit per cycle. It still aims those bits at any device, inside or outside the window. Load indices are drawn over the full index range, so refused loads, loads during a sweep and loads on the wrap cycle all occur. The window-hold assertion relies on nothing but reset, because any index pair is legal input.

// File: rtl/devwin_pkg.sv
package devwin_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN      = 2'd1,
        ST_RUN_PEND = 2'd2
    } win_state_e;
endpackage

// File: rtl/devwin_decode.sv
module devwin_decode #(
    parameter int NDEV  = 16,
    parameter int IDX_W = $clog2(NDEV)
) (
    input  logic             active,
    input  logic [IDX_W-1:0] lo_idx,
    input  logic [IDX_W-1:0] hi_idx,
    output logic [NDEV-1:0]  en
);
    // One range comparator per device position
    for (genvar g = 0; g < NDEV; g++) begin : g_pos
        localparam logic [IDX_W-1:0] POS = IDX_W'(g);
        assign en[g] = active && (lo_idx <= POS) && (POS <= hi_idx);
    end
endmodule

// File: rtl/devwin_router.sv
module devwin_router #(
    parameter int NDEV  = 16,
    parameter int IDX_W = $clog2(NDEV)
) (
    input  logic [NDEV-1:0]  win_en,
    input  logic [IDX_W-1:0] final_idx,
    input  logic [NDEV-1:0]  last_row,
    output logic [NDEV-1:0]  chain_pls,
    output logic             wrap_hit
);
    logic [NDEV-1:0] hit_vec;

    assign chain_pls[0] = 1'b0;

    // Handoff from device g-1 to device g when g-1 is in window and not final
    for (genvar g = 1; g < NDEV; g++) begin : g_chain
        localparam logic [IDX_W-1:0] PREV = IDX_W'(g - 1);
        assign chain_pls[g] = last_row[g-1] && win_en[g-1] && (final_idx != PREV);
    end

    // Final device of the window signals the wrap
    for (genvar g = 0; g < NDEV; g++) begin : g_wrap
        localparam logic [IDX_W-1:0] POS = IDX_W'(g);
        assign hit_vec[g] = last_row[g] && win_en[g] && (final_idx == POS);
    end

    assign wrap_hit = |hit_vec;
endmodule

// File: rtl/devwin_fsm.sv
module devwin_fsm
    import devwin_pkg::*;
#(
    parameter int NDEV  = 16,
    parameter int IDX_W = $clog2(NDEV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] ld_first,
    input  logic [IDX_W-1:0] ld_final,
    input  logic             wrap_hit,
    input  logic [NDEV-1:0]  chain_pls,
    output win_state_e       state,
    output logic             act_valid,
    output logic [IDX_W-1:0] act_first,
    output logic [IDX_W-1:0] act_final,
    output logic [NDEV-1:0]  start_pls,
    output logic             cfg_err
);
    win_state_e       state_q, state_d;
    logic [IDX_W-1:0] act_f_q, act_f_d, act_l_q, act_l_d;
    logic [IDX_W-1:0] pnd_f_q, pnd_f_d, pnd_l_q, pnd_l_d;
    logic [NDEV-1:0]  start_q, start_d;
    logic             err_q, err_d;
    logic             load_ok, load_bad;

    function automatic logic [NDEV-1:0] sel1(input logic [IDX_W-1:0] k);
        logic [NDEV-1:0] v;
        v    = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    assign load_ok  = load && (ld_first <= ld_final);
    assign load_bad = load && (ld_first > ld_final);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            act_f_q <= '0;
            act_l_q <= '0;
            pnd_f_q <= '0;
            pnd_l_q <= '0;
            start_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            act_f_q <= act_f_d;
            act_l_q <= act_l_d;
            pnd_f_q <= pnd_f_d;
            pnd_l_q <= pnd_l_d;
            start_q <= start_d;
            err_q   <= err_d;
        end
    end

    // Next state and next outputs
    always_comb begin
        state_d = state_q;
        act_f_d = act_f_q;
        act_l_d = act_l_q;
        pnd_f_d = pnd_f_q;
        pnd_l_d = pnd_l_q;
        start_d = chain_pls;
        unique case (state_q)
            ST_IDLE: begin
                start_d = '0;
                if (load_ok) begin
                    state_d = ST_RUN;
                    act_f_d = ld_first;
                    act_l_d = ld_final;
                    start_d = sel1(ld_first);
                end
            end
            ST_RUN: begin
                if (wrap_hit) begin
                    start_d = start_d | sel1(act_f_q);
                end
                if (load_ok) begin
                    state_d = ST_RUN_PEND;
                    pnd_f_d = ld_first;
                    pnd_l_d = ld_final;
                end
            end
            ST_RUN_PEND: begin
                if (wrap_hit) begin
                    act_f_d = pnd_f_q;
                    act_l_d = pnd_l_q;
                    start_d = start_d | sel1(pnd_f_q);
                    state_d = ST_RUN;
                end
                if (load_ok) begin
                    state_d = ST_RUN_PEND;
                    pnd_f_d = ld_first;
                    pnd_l_d = ld_final;
                end
            end
            default: begin
                state_d = ST_IDLE;
                start_d = '0;
            end
        endcase
        if (load_ok) begin
            err_d = 1'b0;
        end else if (load_bad) begin
            err_d = 1'b1;
        end else begin
            err_d = err_q;
        end
    end

    assign state     = state_q;
    assign act_valid = (state_q != ST_IDLE);
    assign act_first = act_f_q;
    assign act_final = act_l_q;
    assign start_pls = start_q;
    assign cfg_err   = err_q;

    // R3: a kick from idle yields a running state with one start pulse
    a_r3_idle_kick: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && load_ok) |=> (state_q == ST_RUN && $onehot(start_q)));

    // R7: a refused load raises the error flag
    a_r7_refuse_flags: assert property (@(posedge clk) disable iff (!rst_n)
        load_bad |=> err_q);

    // R8: the active window never moves except at a wrap
    a_r8_window_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !wrap_hit) |=> ($stable(act_f_q) && $stable(act_l_q)));
endmodule

// File: rtl/devwin_ctrl.sv
module devwin_ctrl
    import devwin_pkg::*;
#(
    parameter int NDEV  = 16,
    parameter int IDX_W = $clog2(NDEV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_first,
    input  logic [IDX_W-1:0] load_final,
    input  logic [NDEV-1:0]  last_row,
    output logic [NDEV-1:0]  dev_start,
    output logic [NDEV-1:0]  dev_en,
    output logic             cfg_err
);
    win_state_e       state;
    logic             act_valid;
    logic [IDX_W-1:0] act_first, act_final;
    logic [NDEV-1:0]  chain_pls;
    logic             wrap_hit;

    devwin_decode #(.NDEV(NDEV), .IDX_W(IDX_W)) u_decode (
        .active (act_valid),
        .lo_idx (act_first),
        .hi_idx (act_final),
        .en     (dev_en)
    );

    devwin_router #(.NDEV(NDEV), .IDX_W(IDX_W)) u_router (
        .win_en    (dev_en),
        .final_idx (act_final),
        .last_row  (last_row),
        .chain_pls (chain_pls),
        .wrap_hit  (wrap_hit)
    );

    devwin_fsm #(.NDEV(NDEV), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_first  (load_first),
        .ld_final  (load_final),
        .wrap_hit  (wrap_hit),
        .chain_pls (chain_pls),
        .state     (state),
        .act_valid (act_valid),
        .act_first (act_first),
        .act_final (act_final),
        .start_pls (dev_start),
        .cfg_err   (cfg_err)
    );

    // R6: start pulses only reach enabled devices
    a_r6_start_inside: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_start & ~dev_en) == '0));

    // R2: no window, no enables
    a_r2_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (dev_en == '0));

    // R5: a wrap always restarts some device
    a_r5_wrap_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_hit |=> (dev_start != '0));

    // R4: one in-window flag produces at most one start pulse
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(last_row & dev_en) |=> $onehot0(dev_start));
endmodule

// File: tb/tb_devwin_ctrl.sv
`timescale 1ns/1ps
module tb_devwin_ctrl;
    localparam int NDEV  = 16;
    localparam int IDX_W = 4;
    localparam longint CAP = 64 * 1024 * 1024;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load = 1'b0;
    logic [IDX_W-1:0] load_first = '0;
    logic [IDX_W-1:0] load_final = '0;
    logic [NDEV-1:0]  last_row = '0;
    logic [NDEV-1:0]  dev_start, dev_en;
    logic             cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    bit              m_act, m_pv, m_err;
    int              m_f, m_l, m_pf, m_pl;
    logic [NDEV-1:0] m_start;
    string           m_tag;

    always #2 clk = ~clk;

    devwin_ctrl #(.NDEV(NDEV), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .load(load), .load_first(load_first),
        .load_final(load_final), .last_row(last_row),
        .dev_start(dev_start), .dev_en(dev_en), .cfg_err(cfg_err)
    );

    function automatic logic [NDEV-1:0] win_mask(bit act, int f, int l);
        logic [NDEV-1:0] v = '0;
        for (int i = 0; i < NDEV; i++) if (act && i >= f && i <= l) v[i] = 1'b1;
        return v;
    endfunction

    function automatic int loc_to_idx(longint loc);
        return int'(loc / CAP);
    endfunction

    task automatic model_step();
        bit ok;
        ok      = (load_first <= load_final);
        m_start = '0;
        m_tag   = "R4";
        if (!m_act) begin
            if (load && ok) begin
                m_act = 1; m_f = load_first; m_l = load_final;
                m_start[m_f] = 1'b1; m_tag = "R3";
            end
        end else begin
            for (int i = m_f; i < m_l; i++) if (last_row[i]) m_start[i+1] = 1'b1;
            if (last_row[m_l]) begin
                m_tag = "R5";
                if (m_pv) begin
                    m_f = m_pf; m_l = m_pl; m_pv = 0; m_tag = "R8";
                end
                m_start[m_f] = 1'b1;
            end
            if (load && ok) begin
                m_pv = 1; m_pf = load_first; m_pl = load_final;
            end
        end
        if (load && ok) m_err = 0;
        else if (load) m_err = 1;
    endtask

    task automatic check(string req, logic [NDEV-1:0] act, logic [NDEV-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(m_tag, dev_start, m_start);
        check("R2", dev_en, win_mask(m_act, m_f, m_l));
        check("R7", {15'b0, cfg_err}, {15'b0, m_err});
    endtask

    task automatic step(bit ld, int f, int l, logic [NDEV-1:0] lr);
        load = ld; load_first = IDX_W'(f); load_final = IDX_W'(l); last_row = lr;
        cycle();
    endtask

    initial begin
        int s;
        s = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_act = 0; m_pv = 0; m_err = 0; m_f = 0; m_l = 0; m_pf = 0; m_pl = 0;
        // R1 reset state
        check("R1", dev_start, '0);
        check("R1", dev_en, '0);
        check("R1", {15'b0, cfg_err}, '0);

        // R9 window from locations
        step(1, loc_to_idx(64'd193 * 1024 * 1024), loc_to_idx(64'd520 * 1024 * 1024), '0);
        check("R9", dev_en, 16'h01F8);
        step(0, 0, 0, '0);
        // R4 chain walk 3..8
        for (int i = 3; i < 8; i++) step(0, 0, 0, 16'(1) << i);
        // R6 outside flags ignored
        step(0, 0, 0, 16'h0004);
        check("R6", dev_start, '0);
        step(0, 0, 0, 16'h1000);
        check("R6", dev_start, '0);
        // R5 wrap
        step(0, 0, 0, 16'h0100);
        check("R5", dev_start, 16'h0008);
        // R7 refused load
        step(1, 9, 2, '0);
        check("R7", {15'b0, cfg_err}, 16'h0001);
        check("R7", dev_en, 16'h01F8);
        // R8 deferred window
        step(1, 10, 15, '0);
        check("R8", dev_en, 16'h01F8);
        step(0, 0, 0, 16'h0020);
        check("R8", dev_start, 16'h0040);
        step(0, 0, 0, 16'h0100);
        check("R8", dev_start, 16'h0400);
        check("R8", dev_en, 16'hFC00);
        // R10 latest pending wins
        step(1, 0, 1, '0);
        step(1, 14, 15, '0);
        step(0, 0, 0, 16'h8000);
        check("R10", dev_start, 16'h4000);
        check("R10", dev_en, 16'hC000);
        // single-device window at the top end
        step(1, 15, 15, '0);
        step(0, 0, 0, 16'h8000);
        check("R8", dev_start, 16'h8000);
        step(0, 0, 0, 16'h8000);
        check("R5", dev_start, 16'h8000);
        step(0, 0, 0, '0);

        // constrained random
        for (int c = 0; c < 3000; c++) begin
            bit ld;
            logic [NDEV-1:0] lr;
            ld = ($urandom_range(0, 19) == 0);
            lr = '0;
            if ($urandom_range(0, 1) == 1) lr[$urandom_range(0, NDEV-1)] = 1'b1;
            step(ld, $urandom_range(0, NDEV-1), $urandom_range(0, NDEV-1), lr);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule